// File: doc/BRIEF.md
# Extended-state save request sequencer

This block sequences a supervisor-mode save of processor state components into a memory save area. A start pulse captures a 64-bit instruction mask, a user feature mask, a supervisor feature mask, the per-component in-use flags, per-component unmodified flags, the current floating-point control/status value, the current save context and the context recorded by the last restore. From these it forms the requested-feature bitmap and the set of components that actually need storing.

It then issues one store request per selected component, lowest index first, each on a request/acknowledge handshake. After the component stores it writes two 64-bit header words: first the state-present word, then the compaction word. A one-cycle done pulse closes the operation. Data movement, register reads, area offsets and fault checks belong to the surrounding logic. The memory side only has to acknowledge.

The sequencer has six states. IDLE goes to SCAN when start is seen. SCAN goes to STORE when the lowest remaining component is selected. SCAN steps to the next index and stays in SCAN when that component is not selected. SCAN goes to HDR_BV when no selected components remain. STORE goes back to SCAN on a store acknowledge. HDR_BV goes to HDR_CM on a header acknowledge. HDR_CM goes to DONE on a header acknowledge. DONE goes to IDLE after one cycle.

Top module: `xstate_save_seq`

## Requirements
- R1: The requested bitmap is (user_mask OR sup_mask) AND instr_mask. Bits 62:0 of the compaction header word show this bitmap.
- R2: The compaction header word (hdr_sel=1) equals the requested bitmap with bit 63 forced to 1.
- R3: The state-present header word (hdr_sel=0) equals in_use AND bitmap. Bit 1 is also set when bitmap bit 1 is 1 and mxcsr is not 32'h0000_1F80.
- R4: Component 0 and component 2 are each stored only when both their bitmap bit and their in_use bit are 1.
- R5: Component 1 is stored when its bitmap bit is 1 and either in_use[1] is 1 or mxcsr is not 32'h0000_1F80.
- R6: The context-match flag is 1 only when all four fields match: cur_priv equals last_priv, cur_nonroot equals last_nonroot, cur_area equals last_area, and the compaction word equals last_cmask. When the flag is 1, a selected component whose unmod bit is 1 is not stored. When any field differs, unmod has no effect.
- R7: Store requests go out in ascending st_comp order, one at a time. st_req and st_comp hold steady until st_ack is seen.
- R8: Both header words are written after all component stores: the state-present word first, then the compaction word. Each stays on hdr_data with hdr_req high until hdr_ack.
- R9: Once the compaction word is acknowledged, done is high for exactly one cycle, and busy then falls.
- R10: All inputs are captured at the start pulse. A start while busy is ignored: no extra operation follows, and later input changes do not alter the running operation.
- R11: After reset, busy, done, st_req and hdr_req are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a save operation (taken only when idle) |
| instr_mask | input | 64 | Instruction-supplied component mask |
| user_mask | input | 64 | User feature enable mask |
| sup_mask | input | 64 | Supervisor feature enable mask |
| in_use | input | 64 | Per-component in-use flags |
| unmod | input | 3 | Per-component unmodified-since-restore flags |
| mxcsr | input | 32 | Current floating-point control/status value |
| cur_priv | input | 2 | Current privilege level |
| cur_nonroot | input | 1 | Current virtualization non-root flag |
| cur_area | input | 64 | Linear address of the save area |
| last_priv | input | 2 | Privilege level recorded at last restore |
| last_nonroot | input | 1 | Non-root flag recorded at last restore |
| last_area | input | 64 | Area address recorded at last restore |
| last_cmask | input | 64 | Compaction mask recorded at last restore |
| st_req | output | 1 | Component store request |
| st_ack | input | 1 | Component store acknowledge |
| st_comp | output | 2 | Index of component being stored |
| hdr_req | output | 1 | Header word write request |
| hdr_ack | input | 1 | Header write acknowledge |
| hdr_sel | output | 1 | 0 = state-present word, 1 = compaction word |
| hdr_data | output | 64 | Header word value |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Operation in progress |

## Verification
A wrong selection bit appears directly at the ports, as a component store that is missing or extra. A bad index counter shows as a store index that does not ascend, and it appears with the first request after SCAN. Corrupted captured state shows up in the header words, which are compared bit for bit at their handshakes. A stuck or mis-ordered state machine shows as a header word sent before a store, a done pulse longer than one cycle, or a second operation started by a start pulse that should have been ignored. Each of these is visible within a few cycles of the faulty step.

// File: rtl/xss_pkg.sv
package xss_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_SCAN,
        S_STORE,
        S_HDR_BV,
        S_HDR_CM,
        S_DONE
    } seq_state_t;
endpackage

// File: rtl/xss_select.sv
module xss_select #(
    parameter int MASK_W     = 64,
    parameter int NCOMP      = 3,
    parameter int SSE_IDX    = 1,
    parameter int MXCSR_W    = 32,
    parameter logic [MXCSR_W-1:0] MXCSR_INIT = 32'h0000_1F80,
    parameter int ADDR_W     = 64,
    parameter int PRIV_W     = 2
) (
    input  logic [MASK_W-1:0]  instr_mask,
    input  logic [MASK_W-1:0]  user_mask,
    input  logic [MASK_W-1:0]  sup_mask,
    input  logic [MASK_W-1:0]  in_use,
    input  logic [NCOMP-1:0]   unmod,
    input  logic [MXCSR_W-1:0] mxcsr,
    input  logic [PRIV_W-1:0]  cur_priv,
    input  logic               cur_nonroot,
    input  logic [ADDR_W-1:0]  cur_area,
    input  logic [PRIV_W-1:0]  last_priv,
    input  logic               last_nonroot,
    input  logic [ADDR_W-1:0]  last_area,
    input  logic [MASK_W-1:0]  last_cmask,
    output logic [NCOMP-1:0]   pend,
    output logic [MASK_W-1:0]  bv_word,
    output logic [MASK_W-1:0]  cm_word
);
    logic [MASK_W-1:0] rfbm;
    logic              mx_dirty;
    logic              ctx_match;

    assign rfbm     = (user_mask | sup_mask) & instr_mask;
    assign cm_word  = rfbm | {1'b1, {(MASK_W-1){1'b0}}};
    assign mx_dirty = (mxcsr != MXCSR_INIT);
    assign ctx_match = (cur_priv == last_priv) && (cur_nonroot == last_nonroot)
                    && (cur_area == last_area) && (cm_word == last_cmask);

    always_comb begin
        bv_word = in_use & rfbm;
        if (rfbm[SSE_IDX] && mx_dirty)
            bv_word[SSE_IDX] = 1'b1;
    end

    for (genvar i = 0; i < NCOMP; i++) begin : g_comp
        logic need;
        if (i == SSE_IDX) begin : g_sse
            assign need = rfbm[i] & (in_use[i] | mx_dirty);
        end else begin : g_plain
            assign need = rfbm[i] & in_use[i];
        end
        assign pend[i] = need & ~(ctx_match & unmod[i]);
    end
endmodule

// File: rtl/xss_seq.sv
module xss_seq
    import xss_pkg::*;
#(
    parameter int MASK_W = 64,
    parameter int NCOMP  = 3,
    localparam int IDX_W = (NCOMP > 1) ? $clog2(NCOMP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NCOMP-1:0]  sel_pend,
    input  logic [MASK_W-1:0] sel_bv,
    input  logic [MASK_W-1:0] sel_cm,
    input  logic              st_ack,
    input  logic              hdr_ack,
    output logic              st_req,
    output logic [IDX_W-1:0]  st_comp,
    output logic              hdr_req,
    output logic              hdr_sel,
    output logic [MASK_W-1:0] hdr_data,
    output logic              done,
    output logic              busy
);
    seq_state_t        state, nstate;
    logic [NCOMP-1:0]  pend_q;
    logic [MASK_W-1:0] bv_q, cm_q;
    logic [IDX_W-1:0]  idx;

    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE:   if (start) nstate = S_SCAN;
            S_SCAN:   if (pend_q == '0) nstate = S_HDR_BV;
                      else if (pend_q[0]) nstate = S_STORE;
            S_STORE:  if (st_ack) nstate = S_SCAN;
            S_HDR_BV: if (hdr_ack) nstate = S_HDR_CM;
            S_HDR_CM: if (hdr_ack) nstate = S_DONE;
            S_DONE:   nstate = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            pend_q <= '0;
            bv_q   <= '0;
            cm_q   <= '0;
            idx    <= '0;
        end else begin
            state <= nstate;
            if (state == S_IDLE && start) begin
                pend_q <= sel_pend;
                bv_q   <= sel_bv;
                cm_q   <= sel_cm;
                idx    <= '0;
            end else if ((state == S_SCAN && pend_q != '0 && !pend_q[0]) ||
                         (state == S_STORE && st_ack)) begin
                pend_q <= pend_q >> 1;
                idx    <= idx + 1'b1;
            end
        end
    end

    always_comb begin
        st_req   = 1'b0;
        hdr_req  = 1'b0;
        hdr_sel  = 1'b0;
        hdr_data = '0;
        done     = 1'b0;
        busy     = 1'b1;
        st_comp  = idx;
        unique case (state)
            S_IDLE:   busy = 1'b0;
            S_SCAN:   ;
            S_STORE:  st_req = 1'b1;
            S_HDR_BV: begin hdr_req = 1'b1; hdr_data = bv_q; end
            S_HDR_CM: begin hdr_req = 1'b1; hdr_sel = 1'b1; hdr_data = cm_q; end
            S_DONE:   done = 1'b1;
        endcase
    end

    // checker state: index of last accepted store in this operation
    logic [IDX_W-1:0] prev_comp;
    logic             prev_v;
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            prev_v    <= 1'b0;
            prev_comp <= '0;
        end else if (st_req && st_ack) begin
            prev_v    <= 1'b1;
            prev_comp <= st_comp;
        end
    end

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_req && !st_ack |=> st_req && $stable(st_comp));
    p_ascend_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_req) && prev_v |-> st_comp > prev_comp);
    p_hdr_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_req && !hdr_sel && hdr_ack |=> hdr_req && hdr_sel && !st_req);
    p_hdr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_req && !hdr_ack |=> hdr_req && $stable(hdr_sel) && $stable(hdr_data));
    p_cm_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_req && hdr_sel |-> hdr_data[MASK_W-1]);
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);
    p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done && start |=> busy);
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !st_req && !hdr_req && !done);
endmodule

// File: rtl/xstate_save_seq.sv
module xstate_save_seq #(
    parameter int MASK_W  = 64,
    parameter int NCOMP   = 3,
    parameter int MXCSR_W = 32,
    parameter int ADDR_W  = 64,
    parameter int PRIV_W  = 2,
    localparam int IDX_W  = (NCOMP > 1) ? $clog2(NCOMP) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [MASK_W-1:0]  instr_mask,
    input  logic [MASK_W-1:0]  user_mask,
    input  logic [MASK_W-1:0]  sup_mask,
    input  logic [MASK_W-1:0]  in_use,
    input  logic [NCOMP-1:0]   unmod,
    input  logic [MXCSR_W-1:0] mxcsr,
    input  logic [PRIV_W-1:0]  cur_priv,
    input  logic               cur_nonroot,
    input  logic [ADDR_W-1:0]  cur_area,
    input  logic [PRIV_W-1:0]  last_priv,
    input  logic               last_nonroot,
    input  logic [ADDR_W-1:0]  last_area,
    input  logic [MASK_W-1:0]  last_cmask,
    output logic               st_req,
    input  logic               st_ack,
    output logic [IDX_W-1:0]   st_comp,
    output logic               hdr_req,
    input  logic               hdr_ack,
    output logic               hdr_sel,
    output logic [MASK_W-1:0]  hdr_data,
    output logic               done,
    output logic               busy
);
    logic [NCOMP-1:0]  pend;
    logic [MASK_W-1:0] bv_word, cm_word;

    xss_select #(
        .MASK_W(MASK_W), .NCOMP(NCOMP), .SSE_IDX(1), .MXCSR_W(MXCSR_W),
        .MXCSR_INIT(MXCSR_W'(32'h0000_1F80)), .ADDR_W(ADDR_W), .PRIV_W(PRIV_W)
    ) u_sel (
        .instr_mask(instr_mask), .user_mask(user_mask), .sup_mask(sup_mask),
        .in_use(in_use), .unmod(unmod), .mxcsr(mxcsr),
        .cur_priv(cur_priv), .cur_nonroot(cur_nonroot), .cur_area(cur_area),
        .last_priv(last_priv), .last_nonroot(last_nonroot), .last_area(last_area),
        .last_cmask(last_cmask),
        .pend(pend), .bv_word(bv_word), .cm_word(cm_word)
    );

    xss_seq #(.MASK_W(MASK_W), .NCOMP(NCOMP)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .sel_pend(pend), .sel_bv(bv_word), .sel_cm(cm_word),
        .st_ack(st_ack), .hdr_ack(hdr_ack),
        .st_req(st_req), .st_comp(st_comp),
        .hdr_req(hdr_req), .hdr_sel(hdr_sel), .hdr_data(hdr_data),
        .done(done), .busy(busy)
    );
endmodule

// File: tb/sim_xstate_save_seq.sv
module sim_xstate_save_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] instr_mask = '0, user_mask = '0, sup_mask = '0, in_use = '0;
    logic [2:0]  unmod = '0;
    logic [31:0] mxcsr = 32'h1F80;
    logic [1:0]  cur_priv = '0, last_priv = '0;
    logic        cur_nonroot = 1'b0, last_nonroot = 1'b0;
    logic [63:0] cur_area = '0, last_area = '0, last_cmask = '0;
    logic        st_ack = 1'b0, hdr_ack = 1'b0;
    logic        st_req, hdr_req, hdr_sel, done, busy;
    logic [1:0]  st_comp;
    logic [63:0] hdr_data;

    always #2 clk = ~clk;

    xstate_save_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .instr_mask(instr_mask), .user_mask(user_mask), .sup_mask(sup_mask),
        .in_use(in_use), .unmod(unmod), .mxcsr(mxcsr),
        .cur_priv(cur_priv), .cur_nonroot(cur_nonroot), .cur_area(cur_area),
        .last_priv(last_priv), .last_nonroot(last_nonroot), .last_area(last_area),
        .last_cmask(last_cmask),
        .st_req(st_req), .st_ack(st_ack), .st_comp(st_comp),
        .hdr_req(hdr_req), .hdr_ack(hdr_ack), .hdr_sel(hdr_sel), .hdr_data(hdr_data),
        .done(done), .busy(busy)
    );

    int n_chk = 0, n_bad = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // expected values from the requirements
    function automatic logic [63:0] f_rfbm(input logic [63:0] u, s, m);
        return (u | s) & m;
    endfunction
    function automatic logic [63:0] f_cm(input logic [63:0] r);
        return r | 64'h8000_0000_0000_0000;
    endfunction
    function automatic logic [63:0] f_bv(input logic [63:0] r, iu, input logic [31:0] mx);
        logic [63:0] v;
        v = iu & r;
        if (r[1] && mx != 32'h1F80) v[1] = 1'b1;
        return v;
    endfunction
    function automatic logic [2:0] f_pend(input logic [63:0] r, iu, input logic [31:0] mx,
                                          input logic match, input logic [2:0] um);
        logic [2:0] p;
        p[0] = r[0] & iu[0];
        p[1] = r[1] & (iu[1] | (mx != 32'h1F80));
        p[2] = r[2] & iu[2];
        if (match) p = p & ~um;
        return p;
    endfunction

    // monitor / stub memory state
    logic [2:0]  log_mask;
    int          n_st, last_c, hdr_n, done_cnt = 0;
    bit          order_bad, hold_bad, after_hdr_bad, hdr_seq_bad, done_wide;
    logic [63:0] got_bv, got_cm;
    bit          st_wait = 0, hd_wait = 0, prev_done = 0;
    logic [1:0]  wait_comp;

    initial begin
        forever begin
            @(negedge clk);
            if (st_wait && (!st_req || st_comp != wait_comp)) hold_bad = 1;
            if (hd_wait && !hdr_req) hold_bad = 1;
            st_wait = 0; hd_wait = 0;
            if (done) begin
                if (prev_done) done_wide = 1;
                else done_cnt++;
            end
            prev_done = done;
            if (st_ack || hdr_ack) begin
                st_ack = 0; hdr_ack = 0;
            end else if (st_req) begin
                if ($urandom % 3 != 0) begin
                    st_ack = 1;
                    if (hdr_n != 0) after_hdr_bad = 1;
                    if (int'(st_comp) <= last_c) order_bad = 1;
                    last_c = int'(st_comp);
                    log_mask[st_comp] = 1'b1;
                    n_st++;
                end else begin
                    st_wait = 1; wait_comp = st_comp;
                end
            end else if (hdr_req) begin
                if ($urandom % 3 != 0) begin
                    hdr_ack = 1;
                    if (hdr_sel != (hdr_n == 1)) hdr_seq_bad = 1;
                    if (hdr_n == 0) got_bv = hdr_data; else got_cm = hdr_data;
                    hdr_n++;
                end else hd_wait = 1;
            end
        end
    end

    task automatic go(input string nm, input bit restart);
        logic [63:0] r, e_cm, e_bv;
        logic [2:0]  e_p;
        logic        match;
        int          d0;
        r     = f_rfbm(user_mask, sup_mask, instr_mask);
        e_cm  = f_cm(r);
        e_bv  = f_bv(r, in_use, mxcsr);
        match = (cur_priv == last_priv) && (cur_nonroot == last_nonroot) &&
                (cur_area == last_area) && (e_cm == last_cmask);
        e_p   = f_pend(r, in_use, mxcsr, match, unmod);
        log_mask = '0; n_st = 0; last_c = -1; hdr_n = 0;
        order_bad = 0; hold_bad = 0; after_hdr_bad = 0; hdr_seq_bad = 0; done_wide = 0;
        got_bv = 'x; got_cm = 'x;
        d0 = done_cnt;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        // change inputs after capture (R10)
        instr_mask = ~instr_mask; in_use = ~in_use; unmod = ~unmod;
        mxcsr = mxcsr ^ 32'h40;
        if (restart) begin
            @(negedge clk);
            if (busy && !done) begin start = 1; @(negedge clk); start = 0; end
        end
        while (done_cnt == d0) @(negedge clk);
        chk(log_mask == e_p, {nm, " R4 R5 R6 store set"}, 64'(log_mask), 64'(e_p));
        chk(!order_bad && !hold_bad, {nm, " R7 order/hold"}, 64'(order_bad), 0);
        chk(got_bv == e_bv, {nm, " R3 state-present word"}, got_bv, e_bv);
        chk(got_cm == e_cm, {nm, " R1 R2 compaction word"}, got_cm, e_cm);
        chk(!after_hdr_bad && !hdr_seq_bad && hdr_n == 2, {nm, " R8 header order"},
            64'(hdr_n), 2);
        repeat (3) @(negedge clk);
        chk(!done_wide, {nm, " R9 done width"}, 64'(done_wide), 0);
        chk(!busy && !st_req && !hdr_req && done_cnt == d0 + 1,
            {nm, " R10 no extra operation"}, 64'(busy), 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !st_req && !hdr_req, "R11 reset outputs (held)",
            {60'd0, busy, done, st_req, hdr_req}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !done && !st_req && !hdr_req, "R11 reset outputs",
            {60'd0, busy, done, st_req, hdr_req}, 0);

        // directed: empty bitmap
        user_mask = 0; sup_mask = 0; instr_mask = '1; in_use = '1;
        go("empty", 0);
        // directed: all three selected
        user_mask = 64'h7; sup_mask = 0; instr_mask = '1; in_use = 64'h7; mxcsr = 32'h1F80;
        go("all3", 1);
        // directed: SSE saved via mxcsr only (R5)
        user_mask = 64'h3; sup_mask = 64'h4; instr_mask = 64'h6; in_use = 0;
        mxcsr = 32'h1F81;
        go("mxcsr", 1);
        // directed: context match skips unmodified (R6)
        user_mask = 64'h1; sup_mask = 64'h6; instr_mask = '1; in_use = 64'h7;
        mxcsr = 32'h1F80; unmod = 3'b101;
        cur_priv = 0; last_priv = 0; cur_nonroot = 1; last_nonroot = 1;
        cur_area = 64'h1000; last_area = 64'h1000; last_cmask = 64'h8000_0000_0000_0007;
        go("match", 0);
        // directed: one field differs, unmod ignored (R6)
        user_mask = 64'h1; sup_mask = 64'h6; instr_mask = '1; in_use = 64'h7; unmod = 3'b111;
        mxcsr = 32'h1F80; last_area = 64'h1040;
        go("mismatch", 0);

        for (int k = 0; k < 60; k++) begin
            user_mask  = {$urandom, $urandom};
            sup_mask   = {$urandom, $urandom} & {$urandom, $urandom};
            instr_mask = {$urandom, $urandom} | 64'(k & 7);
            in_use     = {$urandom, $urandom};
            unmod      = 3'($urandom);
            mxcsr      = ($urandom % 2) ? 32'h1F80 : $urandom;
            cur_priv   = 2'($urandom); cur_nonroot = 1'($urandom);
            cur_area   = {$urandom, $urandom} & ~64'h3F;
            if ($urandom % 2) begin
                last_priv = cur_priv; last_nonroot = cur_nonroot; last_area = cur_area;
                last_cmask = f_cm(f_rfbm(user_mask, sup_mask, instr_mask));
            end else begin
                last_priv = 2'($urandom); last_nonroot = 1'($urandom);
                last_area = {$urandom, $urandom}; last_cmask = {$urandom, $urandom};
            end
            go("rand", (k % 2) == 0);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog R9 act=%h exp=%h", 64'd0, 64'd1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule